// File: doc/BRIEF.md
# Byte-Window Fuse Reader

This block serves byte-granular reads from a 128-byte one-time-programmable fuse array that can only be read a 32-bit word at a time. A requester gives a byte offset and a byte count. The block adds a fixed base of 96 to the offset, so the bottom 96 bytes of the array are never reachable and offset 0 means the first byte of the public 32-byte region. It then walks the aligned words that cover the window and issues one word read per word. It drops the leading bytes of the first word and the trailing bytes of the last one, and sends exactly the requested bytes, lowest address first, on a byte stream that has a last flag.

The block takes one request at a time. It rejects a request that is empty or that runs past the top of the array, and it issues no read for it. It also abandons a transfer when the fuse port fails to answer within a set number of cycles. In both cases it raises a one-cycle error pulse.

Top module: `fuse_window_reader`

## Requirements
- R1: Out of reset, req_ready is 1 and rd_req, out_valid, out_last and err are all 0.
- R2: Requested byte k (offset plus position) is array byte 96+k. No read ever carries a word address below 24, so no secure byte is ever read.
- R3: For an accepted request with adjusted start A=offset+96 and length L, the word reads go to addresses floor(A/4) upward, one step at a time. Their number is ceil((A+L)/4) - floor(A/4).
- R4: Inside a returned word, byte address 4w+i sits in rd_data bits 8i+7:8i (little-endian). The first output byte comes from lane A mod 4, and the bytes follow in ascending address order, one per cycle within a word.
- R5: Exactly L bytes are sent with out_valid. out_last is 1 on the final byte only.
- R6: req_ready is 0 from the cycle after a request is accepted until the final byte has been sent. It is 1 again in the next cycle.
- R7: A request with L=0 or with A+L>128 is taken and rejected. err is 1 for exactly the cycle after it is accepted, and no read is issued and no byte is sent.
- R8: rd_req stays 1 with an unchanged rd_addr until rd_done is seen. rd_done is only taken while rd_req is 1.
- R9: If rd_done does not arrive within TIMEOUT cycles of rd_req rising, rd_req falls and err pulses. No further byte of that transfer is sent, and the block becomes ready again. Bytes already sent from earlier words stand.
- R10: A read whose rd_done arrives in the TIMEOUT-th cycle of the wait, and not later, still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_offset | input | OFS_W | Byte offset inside the public region |
| req_len | input | LEN_W | Number of bytes wanted |
| rd_addr | output | ADDR_W | Word address for the fuse port |
| rd_req | output | 1 | Word read request, held until done |
| rd_data | input | 32 | Word returned by the fuse port |
| rd_done | input | 1 | rd_data is valid this cycle |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | out_data is valid |
| out_last | output | 1 | Final byte of the transfer |
| err | output | 1 | One-cycle pulse: request rejected or read timed out |

## Verification
A wrong word counter or lane pointer shows at the ports within the same transfer. The byte on out_data stops matching the fuse pattern value for its address, or an extra or missing read appears on the port, before out_last. A wrong remaining-byte count shows as out_last on the wrong byte, or as req_ready coming back too early or too late, in the cycle after the last byte. A broken range check or timeout shows one cycle after acceptance, or one cycle after the wait limit: an err pulse that is missing or spurious, or a read that should never have started. The sweep covers every offset and length around the public region's edges with a variety of port latencies, so each of these faults is reached.

// File: rtl/fwr_pkg.sv
// Shared constants and types for the byte-window fuse reader.
package fwr_pkg;
    localparam int WORD_BYTES = 4;
    localparam int LANE_W     = 2;
    localparam int WORD_W     = 8 * WORD_BYTES;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EMIT = 2'd2
    } fwr_state_e;
endpackage

// File: rtl/fwr_window.sv
// Window decode: adds the hidden base to the request offset, then finds the
// first word, the first lane and whether the window is legal.
// Assumes ARRAY_BYTES is a multiple of 4 and SECURE_BYTES < ARRAY_BYTES.
module fwr_window #(
    parameter int ARRAY_BYTES  = 128,
    parameter int SECURE_BYTES = 96,
    parameter int OFS_W        = 8,
    parameter int LEN_W        = 8,
    parameter int ADDR_W       = 5
) (
    input  logic [OFS_W-1:0]  offset,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] first_word,
    output logic [1:0]        first_lane,
    output logic              bad
);
    localparam int SUM_W = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + $clog2(ARRAY_BYTES) + 1;

    logic [SUM_W-1:0] adj;
    logic [SUM_W-1:0] stop;

    // Adjusted start, exclusive end and the legality test.
    always_comb begin
        adj        = SUM_W'(offset) + SUM_W'(SECURE_BYTES);
        stop       = adj + SUM_W'(len);
        bad        = (len == '0) || (stop > SUM_W'(ARRAY_BYTES));
        first_word = ADDR_W'(adj >> 2);
        first_lane = adj[1:0];
    end
endmodule

// File: rtl/fwr_timer.sv
// Wait timer: counts cycles while a word read is pending. It flags expiry
// in the TIMEOUT-th cycle. Assumes TIMEOUT >= 2.
module fwr_timer #(
    parameter int TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT);

    logic [CNT_W-1:0] cnt;

    // Expiry when the count reaches the final allowed cycle.
    assign expired = run && (cnt == CNT_W'(TIMEOUT - 1));

    // Count up while running, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fwr_lane_pick.sv
// Lane selector: picks one little-endian byte out of a fuse word.
module fwr_lane_pick
    import fwr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        byte_out
);
    logic [7:0] lanes [WORD_BYTES];

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    // Select the addressed lane.
    assign byte_out = lanes[lane];
endmodule

// File: rtl/fuse_window_reader.sv
// Byte-window fuse reader top. Requests are taken one at a time. Each
// covering word is read, then its wanted bytes are sent one per cycle,
// and the next word is read after that. The output has no backpressure.
// Assumes the fuse port raises rd_done for one cycle while rd_req is high.
module fuse_window_reader
    import fwr_pkg::*;
#(
    parameter int ARRAY_BYTES  = 128,
    parameter int SECURE_BYTES = 96,
    parameter int OFS_W        = 8,
    parameter int LEN_W        = 8,
    parameter int TIMEOUT      = 64,
    localparam int ADDR_W      = $clog2(ARRAY_BYTES / WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [LEN_W-1:0]  req_len,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_req,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_done,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              out_last,
    output logic              err
);
    fwr_state_e        state;
    logic [ADDR_W-1:0] word_q;
    logic [LANE_W-1:0] lane_q;
    logic [LEN_W-1:0]  left_q;
    logic [WORD_W-1:0] data_q;
    logic              err_q;

    logic [ADDR_W-1:0] first_word;
    logic [1:0]        first_lane;
    logic              bad;
    logic              expired;

    fwr_window #(
        .ARRAY_BYTES (ARRAY_BYTES),
        .SECURE_BYTES(SECURE_BYTES),
        .OFS_W       (OFS_W),
        .LEN_W       (LEN_W),
        .ADDR_W      (ADDR_W)
    ) u_window (
        .offset    (req_offset),
        .len       (req_len),
        .first_word(first_word),
        .first_lane(first_lane),
        .bad       (bad)
    );

    fwr_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_READ),
        .expired(expired)
    );

    fwr_lane_pick u_pick (
        .word    (data_q),
        .lane    (lane_q),
        .byte_out(out_data)
    );

    // Port-side outputs decoded from state.
    assign req_ready = (state == ST_IDLE);
    assign rd_req    = (state == ST_READ);
    assign rd_addr   = word_q;
    assign out_valid = (state == ST_EMIT);
    assign out_last  = (state == ST_EMIT) && (left_q == LEN_W'(1));
    assign err       = err_q;

    // Transfer sequencer: accept or reject, read a word, send its bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            word_q <= '0;
            lane_q <= '0;
            left_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (bad) begin
                            err_q <= 1'b1;
                        end else begin
                            word_q <= first_word;
                            lane_q <= first_lane;
                            left_q <= req_len;
                            state  <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_done) begin
                        data_q <= rd_data;
                        state  <= ST_EMIT;
                    end else if (expired) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_EMIT: begin
                    left_q <= left_q - 1'b1;
                    lane_q <= lane_q + 1'b1;
                    if (left_q == LEN_W'(1)) begin
                        state <= ST_IDLE;
                    end else if (lane_q == LANE_W'(WORD_BYTES - 1)) begin
                        word_q <= word_q + 1'b1;
                        state  <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fwr_checker.sv
// Protocol checker for the byte-window fuse reader, bound to the top.
module fwr_checker #(
    parameter int SECURE_BYTES = 96,
    parameter int TIMEOUT      = 64,
    parameter int ADDR_W       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_req,
    input logic              rd_done,
    input logic              out_valid,
    input logic              out_last,
    input logic              err
);
    localparam int WC_W = $clog2(TIMEOUT + 1) + 1;

    logic [WC_W-1:0] wait_cnt;

    // Count consecutive cycles of an unanswered read.
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_req || rd_done) begin
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // R2
    secure_words_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (32'(rd_addr) >= SECURE_BYTES / 4));

    // R5
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6
    busy_while_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !req_ready);

    // R8
    read_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done) |=> (rd_req || err));

    // R8
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done) |=> (!rd_req || $stable(rd_addr)));

    // R9
    wait_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (32'(wait_cnt) < TIMEOUT));

    // R9
    no_byte_with_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid);
endmodule

bind fuse_window_reader fwr_checker #(
    .SECURE_BYTES(SECURE_BYTES),
    .TIMEOUT     (TIMEOUT),
    .ADDR_W      (ADDR_W)
) u_fwr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rd_addr  (rd_addr),
    .rd_req   (rd_req),
    .rd_done  (rd_done),
    .out_valid(out_valid),
    .out_last (out_last),
    .err      (err)
);

// File: tb/sim_fuse_window_reader.sv
module sim_fuse_window_reader;
    localparam int TO = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_offset = '0;
    logic [7:0]  req_len = '0;
    logic [4:0]  rd_addr;
    logic        rd_req;
    logic [31:0] rd_data = '0;
    logic        rd_done = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_last;
    logic        err;

    int checks = 0;
    int fails  = 0;

    int lat = 0;
    int hang_from = 1000;
    int reads_seen = 0;
    int addr_bad = 0;
    int exp_addr = 0;
    int wait_cnt = 0;

    always #4 clk = ~clk;

    fuse_window_reader #(.TIMEOUT(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_len(req_len), .rd_addr(rd_addr),
        .rd_req(rd_req), .rd_data(rd_data), .rd_done(rd_done),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .err(err)
    );

    function automatic logic [7:0] fb(int a);
        return 8'((a * 29 + 7) % 256);
    endfunction

    function automatic logic [31:0] word_at(int w);
        return {fb(4*w+3), fb(4*w+2), fb(4*w+1), fb(4*w)};
    endfunction

    // Fuse port model: answers after lat waiting cycles, or never from read hang_from on.
    always @(negedge clk) begin
        rd_done <= 1'b0;
        if (!rd_req || rd_done) begin
            wait_cnt = 0;
        end else if (reads_seen < hang_from) begin
            if (wait_cnt >= lat) begin
                rd_done <= 1'b1;
                rd_data <= word_at(int'(rd_addr));
                if (int'(rd_addr) != exp_addr) addr_bad = addr_bad + 1;
                exp_addr = exp_addr + 1;
                reads_seen = reads_seen + 1;
                wait_cnt = 0;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // One request, fully checked. hang: -1 none, else index of first read never answered.
    task automatic run_req(int off, int len, int hang);
        int adj, nb, cyc, exp_reads, exp_bytes;
        bit bad, got_err, fin;
        adj = off + 96;
        bad = (len == 0) || (adj + len > 128);
        exp_reads = ((adj + len + 3) / 4) - (adj / 4);
        hang_from = (hang < 0) ? 1000 : hang;
        reads_seen = 0; addr_bad = 0; exp_addr = adj / 4;
        @(negedge clk);
        req_valid = 1'b1; req_offset = 8'(off); req_len = 8'(len);
        @(negedge clk);
        req_valid = 1'b0;
        nb = 0; cyc = 0; got_err = 0; fin = 0;
        while (!fin && cyc < 600) begin
            if (out_valid) begin
                chk(out_data == fb(adj + nb), "R2/R4 byte value", out_data, fb(adj + nb));
                chk(out_last == (nb == len - 1), "R5 last flag", out_last, nb == len - 1);
                chk(!req_ready, "R6 ready while sending", req_ready, 0);
                nb++;
                if (out_last) fin = 1;
            end
            if (err) begin got_err = 1; fin = 1; end
            cyc++;
            if (!fin) @(negedge clk);
        end
        chk(cyc < 600, "R5 transfer ends", cyc, 600);
        if (bad) begin
            chk(got_err && cyc == 1, "R7 error pulse after accept", cyc, 1);
            chk(nb == 0 && reads_seen == 0, "R7 nothing read or sent", nb + reads_seen, 0);
        end else if (hang >= 0) begin
            exp_bytes = (hang == 0) ? 0 : (4 - adj % 4);
            chk(got_err, "R9 timeout error", got_err, 1);
            chk(nb == exp_bytes, "R9 bytes before abort", nb, exp_bytes);
        end else begin
            chk(!got_err, "R10 no error", got_err, 0);
            chk(nb == len, "R5 byte count", nb, len);
            chk(reads_seen == exp_reads, "R3 read count", reads_seen, exp_reads);
            chk(addr_bad == 0, "R3 word addresses", addr_bad, 0);
        end
        @(negedge clk);
        chk(req_ready && !err, "R6 ready again", req_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1 && rd_req == 0 && out_valid == 0 && out_last == 0 && err == 0,
            "R1 reset outputs", {req_ready, rd_req, out_valid, out_last, err}, 5'b10000);
        rst_n = 1'b1;
        // R2 R3 R4 R5 R7: sweep offsets and lengths around the public region
        for (int o = 0; o < 36; o++) begin
            for (int l = 0; l < 35; l++) begin
                lat = (o + l) % 4;
                run_req(o, l, -1);
            end
        end
        // R7 far out of range and wide values
        run_req(200, 5, -1);
        run_req(255, 255, -1);
        run_req(0, 255, -1);
        // R10 answer in the last allowed cycle
        lat = TO - 1;
        run_req(3, 9, -1);
        run_req(31, 1, -1);
        // R9 no answer at all, then no answer for the second word
        lat = 1;
        run_req(5, 10, 0);
        run_req(5, 10, 1);
        lat = TO;
        run_req(0, 4, -2 + 2);
        // recovery after timeout: normal transfer
        lat = 2;
        run_req(1, 30, -1);
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule